// File: doc/BRIEF.md
# Serial controller interrupt status and mask unit

This unit gathers seven event sources of a serial controller into one interrupt line. Each event that is high at a clock edge sets a sticky pending bit in the status register. A pending bit stays set until software writes a 1 to that bit at the status address. The mask cannot be written directly. A write to the set address turns on every mask bit written as 1. A write to the clear address turns off every mask bit written as 1. A separate address gives a read-only view of the mask.

The interrupt line is high while any pending bit has its mask bit set. Events are recorded whether or not they are masked. Software handles an interrupt by reading the status register and writing the same value back. This clears exactly the events it has seen, and an event arriving in that same cycle is kept.

The unit also holds the transmit watermark threshold register and presents its value to the FIFO logic. The events arrive from outside as pulses or levels: mode fault on bit 1, transmit level above the watermark on bit 2, transmit full on bit 3, and receive not empty on bit 4. The unit does not generate them.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status and mask registers read 0, the threshold reads 1, and `irq_o` is low.
- R2: An event input high at a clock edge sets its status bit from that edge onward. The bit stays set after the event input returns low.
- R3: A write to address 0x04 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A read of 0x04 returns the status in bits 6:0.
- R4: If an event is high in the same cycle as a write-1 clear of its bit, the bit stays set.
- R5: A write to address 0x08 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A write to address 0x0C clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R7: A read of address 0x10 returns the mask in bits 6:0. Writes to 0x10 are ignored. Reads of 0x08 and 0x0C return 0.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both 1. It follows register updates in the cycle after the updating edge, with no added delay.
- R9: Write data above bit 6 has no effect on the status or mask registers. Read data of the status and mask registers is 0 above bit 6.
- R10: Address 0x28 holds an 8-bit threshold. It is written from data bits 7:0, reads back zero-extended, and drives `thresh_o`.
- R11: Status bits latch events even while their mask bit is 0. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational, 0 when not reading) |
| evt_i | input | 7 | Event sources, one per status bit |
| thresh_o | output | 8 | Transmit watermark threshold |
| irq_o | output | 1 | Level interrupt request |

## Verification
Directed sequences come first:
- A single event pulse that is later read back separates sticky latching from level following.
- Mask writes that carry a mix of 1 and 0 bits, some of them above bit 6, show whether the set and clear addresses touch only the bits written as 1.
- A clear written in the same cycle as a new event on an overlapping bit checks that the event wins.

Seeded random traffic then mixes sparse event bursts with writes and reads at every mapped and unmapped address. In every cycle a bench model predicts the interrupt line, the threshold output and each read value.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned OFS_STATUS = 'h04;
  localparam int unsigned OFS_MSET   = 'h08;
  localparam int unsigned OFS_MCLR   = 'h0C;
  localparam int unsigned OFS_MASK   = 'h10;
  localparam int unsigned OFS_THRESH = 'h28;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_STATUS,
    RSEL_MASK,
    RSEL_THRESH
  } rsel_e;

  typedef struct packed {
    logic stat_w1c;
    logic mask_set;
    logic mask_clr;
    logic thr_wr;
  } wstb_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstb_t             wstb_o,
  output rsel_e             rsel_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THRESH);

  always_comb begin
    wstb_o = '0;
    rsel_o = RSEL_NONE;
    if (sel_i && wr_i) begin
      wstb_o.stat_w1c = (addr_i == A_STAT);
      wstb_o.mask_set = (addr_i == A_MSET);
      wstb_o.mask_clr = (addr_i == A_MCLR);
      wstb_o.thr_wr   = (addr_i == A_THR);
    end else if (sel_i) begin
      if (addr_i == A_STAT)      rsel_o = RSEL_STATUS;
      else if (addr_i == A_MASK) rsel_o = RSEL_MASK;
      else if (addr_i == A_THR)  rsel_o = RSEL_THRESH;
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[i]) bit_q <= 1'b1;
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign mask_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_unit_pkg::*;
#(
  parameter int unsigned N      = 7,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  rsel_e              rsel_i,
  input  logic [N-1:0]       status_i,
  input  logic [N-1:0]       mask_i,
  input  logic [THR_W-1:0]   thr_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    unique case (rsel_i)
      RSEL_STATUS: rdata_o = DATA_W'(status_i);
      RSEL_MASK:   rdata_o = DATA_W'(mask_i);
      RSEL_THRESH: rdata_o = DATA_W'(thr_i);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned THR_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [THR_W-1:0]  thresh_o,
  output logic              irq_o
);
  localparam int unsigned HI = (NUM_SRC > THR_W) ? NUM_SRC : THR_W;

  wstb_t               wstb;
  rsel_e               rsel;
  logic [NUM_SRC-1:0]  wbits;
  logic [NUM_SRC-1:0]  status_q;
  logic [NUM_SRC-1:0]  mask_q;
  logic [THR_W-1:0]    thr_q;
  logic                wdata_unused;

  assign wbits        = wdata_i[NUM_SRC-1:0];
  assign wdata_unused = ^wdata_i[DATA_W-1:HI];

  irq_reg_decode #(.ADDR_W(ADDR_W)) i_dec (
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wstb_o (wstb),
    .rsel_o (rsel)
  );

  irq_status_bank #(.N(NUM_SRC)) i_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_i    (wstb.stat_w1c ? wbits : '0),
    .status_o (status_q)
  );

  irq_mask_bank #(.N(NUM_SRC)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wstb.mask_set ? wbits : '0),
    .clr_i  (wstb.mask_clr ? wbits : '0),
    .mask_o (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          thr_q <= THR_W'(THR_RST);
    else if (wstb.thr_wr) thr_q <= wdata_i[THR_W-1:0];
  end

  irq_rd_mux #(.N(NUM_SRC), .THR_W(THR_W), .DATA_W(DATA_W)) i_rd (
    .rsel_i   (rsel),
    .status_i (status_q),
    .mask_i   (mask_q),
    .thr_i    (thr_q),
    .rdata_o  (rdata_o)
  );

  assign thresh_o = thr_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int unsigned N      = 7,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wbits_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N-1:0]      evt_i,
  input logic              irq_o,
  input logic [N-1:0]      status_q,
  input logic [N-1:0]      mask_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);

  logic wr_stat, wr_mset, wr_mclr, rd_wo;
  assign wr_stat = sel_i && wr_i && (addr_i == A_STAT);
  assign wr_mset = sel_i && wr_i && (addr_i == A_MSET);
  assign wr_mclr = sel_i && wr_i && (addr_i == A_MCLR);
  assign rd_wo   = sel_i && !wr_i && ((addr_i == A_MSET) || (addr_i == A_MCLR));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_mset || wr_mclr) |=> $stable(mask_q));

  a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> ((mask_q & $past(wbits_i)) == $past(wbits_i)));

  a_r6_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mclr |=> ((mask_q & $past(wbits_i)) == '0));

  a_r7_wo_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wo |-> (rdata_o == '0));

  a_r8_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((mask_q != '0) && (status_q != '0)));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:HI] == '0);
endmodule

bind spi_irq_unit irq_unit_chk #(
  .N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI(HI)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wbits_i  (wbits),
  .rdata_o  (rdata_o),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/test_spi_irq_unit.sv
`timescale 1ns/1ps
module test_spi_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  evt = '0;
  logic [7:0]  thresh;
  logic        irq;

  int unsigned n_chk = 0, n_fail = 0;
  logic [6:0]  m_stat = '0, m_mask = '0;
  logic [7:0]  m_thr = 8'd1;

  always #10 clk = ~clk;

  spi_irq_unit i_spi_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .thresh_o(thresh), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h04:   return {25'd0, m_stat};
      8'h10:   return {25'd0, m_mask};
      8'h28:   return {24'd0, m_thr};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_upd(input logic s, input logic w, input logic [7:0] a,
                           input logic [31:0] d, input logic [6:0] e);
    logic [6:0] b;
    b = d[6:0];
    if (s && w) begin
      case (a)
        8'h04: m_stat = m_stat & ~b;
        8'h08: m_mask = m_mask | b;
        8'h0C: m_mask = m_mask & ~b;
        8'h28: m_thr  = d[7:0];
        default: ;
      endcase
    end
    m_stat = m_stat | e;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [6:0] e, input string tag);
    @(negedge clk);
    chk("R8 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    chk("R10 thresh", {24'd0, thresh}, {24'd0, m_thr});
    sel = s; wr = w; addr = a; wdata = d; evt = e;
    #2;
    if (s && !w) chk(tag, rdata, exp_rd(a));
    else chk("R11 idle read", rdata, 32'd0);
    @(posedge clk);
    model_upd(s, w, a, d, e);
  endtask

  initial begin
    #(64'd200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] amap [7];
    amap = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h28, 8'h14, 8'h00};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    step(1, 0, 8'h04, 0, 0, "R1 status");
    step(1, 0, 8'h10, 0, 0, "R1 mask");
    step(1, 0, 8'h28, 0, 0, "R1 thresh");
    // R2 sticky latch of a one-cycle pulse (mode fault, bit 1)
    step(0, 0, 8'h00, 0, 7'h02, "R2");
    step(1, 0, 8'h04, 0, 0, "R2 status");
    step(0, 0, 8'h00, 0, 0, "R2");
    step(1, 0, 8'h04, 0, 0, "R2 still set");
    // R11 latched while masked, irq low
    step(1, 0, 8'h10, 0, 0, "R11 mask zero");
    // R5 set mask bits
    step(1, 1, 8'h08, 32'h02, 0, "R5");
    step(1, 0, 8'h10, 0, 0, "R5 mask");
    step(1, 1, 8'h08, 32'h10, 0, "R5");
    step(1, 0, 8'h10, 0, 0, "R5 mask keeps bit1");
    // R9 upper bits ignored
    step(1, 1, 8'h08, 32'hFFFF_FF80, 0, "R9");
    step(1, 0, 8'h10, 0, 0, "R9 mask");
    // R7 write-only reads, read-only write
    step(1, 0, 8'h08, 0, 0, "R7 set addr read");
    step(1, 0, 8'h0C, 0, 0, "R7 clr addr read");
    step(1, 1, 8'h10, 32'h7F, 0, "R7");
    step(1, 0, 8'h10, 0, 0, "R7 mask unchanged");
    // R6 clear mask bits
    step(1, 1, 8'h0C, 32'h02, 0, "R6");
    step(1, 0, 8'h10, 0, 0, "R6 mask");
    // R4 set beats clear
    step(0, 0, 8'h00, 0, 7'h0C, "R4");
    step(1, 1, 8'h04, 32'h06, 7'h04, "R4");
    step(1, 0, 8'h04, 0, 0, "R4 status");
    // R3 write-1-to-clear, zero bits untouched
    step(1, 1, 8'h04, 32'h08, 0, "R3");
    step(1, 0, 8'h04, 0, 0, "R3 status");
    step(1, 1, 8'h04, 32'h00, 0, "R3");
    step(1, 0, 8'h04, 0, 0, "R3 zero write");
    step(1, 1, 8'h04, 32'hFFFF_FF80, 0, "R9");
    step(1, 0, 8'h04, 0, 0, "R9 status");
    // R10 threshold
    step(1, 1, 8'h28, 32'hABCD_01A5, 0, "R10");
    step(1, 0, 8'h28, 0, 0, "R10 thresh");
    // R11 unmapped
    step(1, 1, 8'h14, 32'hFFFF_FFFF, 0, "R11");
    step(1, 0, 8'h14, 0, 0, "R11 unmapped");
    step(1, 0, 8'h00, 0, 0, "R11 unmapped");
    step(1, 0, 8'h04, 0, 0, "R11 status after unmapped");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic [6:0]  e;
      logic [31:0] d;
      op = $urandom_range(0, 7);
      e  = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
      d  = $urandom;
      if ($urandom_range(0, 1) == 1) d = d & 32'h7F;
      case (op)
        0: step(1, 1, 8'h04, d, e, "R3 random");
        1: step(1, 1, 8'h08, d, e, "R5 random");
        2: step(1, 1, 8'h0C, d, e, "R6 random");
        3: step(1, 1, 8'h28, d, e, "R10 random");
        4: step(1, 0, 8'h04, 0, e, "R2 random read");
        5: step(1, 0, 8'h10, 0, e, "R7 random read");
        6: step(1, 0, amap[$urandom_range(0, 6)], 0, e, "R11 random read");
        default: step(1, 1, amap[$urandom_range(0, 6)], d, e, "R9 random write");
      endcase
    end
    step(0, 0, 8'h00, 0, 0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule